// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits beside a multi-bank SDRAM command bus and follows what every bank is doing. Each clock it turns the chip-select, row strobe, column strobe and write-enable lines into a command. It reads the bank address and the auto-precharge address bit along with it, and advances one small state machine per bank. The tracked phases are idle, row open, plain read or write burst, read or write burst with auto precharge, and precharging.

Bursts in different banks interact. A new READ or WRITE to one bank cuts short a burst running in another. A plain burst then falls back to an open row. An auto-precharge read starts closing its row on the same cycle. An auto-precharge write first waits out the write-recovery time. Any command that the present bank states do not allow produces a one-cycle flag. Such a command leaves every bank as it was. A memory controller model, a protocol monitor or a bus analyser can use the per-bank states and the flag directly.

Top module: `sdram_bank_tracker`

## Requirements
- R1: With cs_n high the cycle is a deselect. With cs_n low, {ras_n,cas_n,we_n} decodes as: 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 110 BURST STOP, 001 REFRESH, 000 MODE LOAD, 111 NOP. Deselect and NOP change no bank and raise no flag.
- R2: Bank b reports its state on bank_state_o[3b+2:3b]. The codes are 0 idle, 1 row open, 2 read, 3 write, 4 read with auto precharge, 5 write with auto precharge and 6 precharging. ACTIVE is legal only to an idle bank, and the bank reads 1 after that edge.
- R3: READ or WRITE is legal only to a bank in state 1, 2 or 3. With a10 low the bank enters 2 or 3. With a10 high it enters 4 or 5. A plain burst returns to 1 exactly BURST_LEN cycles after its command.
- R4: Unless interrupted, a read with auto precharge enters 6 BURST_LEN cycles after its command. A write with auto precharge enters 6 BURST_LEN+T_WR cycles after its command. A bank in 6 returns to 0 T_RP cycles after entering it.
- R5: PRECHARGE with a10 low targets bank ba. It is illegal if that bank is in 4 or 5. With a10 high it targets every bank and is illegal if any bank is in 4 or 5. Targeted banks in 1, 2 or 3 enter 6. Targeted banks in 0 or 6 are unchanged.
- R6: BURST STOP is legal only when bank ba is in 2 or 3, and it returns that bank to 1. Sent to any other bank it is illegal.
- R7: A legal READ or WRITE to bank m moves every other bank that is in 2 or 3 to 1 on that same edge.
- R8: A legal READ or WRITE to bank m moves every other bank that is in 4 to 6 on that same edge.
- R9: A legal READ or WRITE to bank m, arriving while another bank is still bursting in 5, holds that bank in 5 for T_WR cycles. The bank then enters 6.
- R10: REFRESH and MODE LOAD are legal only when all banks are in 0, and they change no bank state.
- R11: A command is evaluated only if cke is high in the current cycle and was high in the previous cycle. Otherwise it has no effect and raises no flag. The first cycle after reset always counts as a previous-cycle low.
- R12: An illegal command sets illegal_o for exactly the cycle after its edge and changes no bank state.
- R13: Synchronous active-high reset puts every bank in 0 and clears illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| bank_state_o | output | NUM_BANKS*3 | Packed per-bank state codes |
| illegal_o | output | 1 | One-cycle flag for a rejected command |

## Verification
A bank whose state or counter is wrong shows up on its own bank_state_o field within one cycle if the next-state choice is wrong. If only a countdown is off, the error appears at the end of the burst, recovery or precharge window, so fields are compared after every edge and not only at the end of a sequence. Because legality depends on all bank states, a stale state in one bank also shows as a wrong illegal_o pulse on the next command aimed at it. Directed sequences pin down the exact edge at which interrupted auto-precharge banks change. A long seeded random run compares every field and the flag against a bench model after every cycle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  localparam int ST_W = 3;

  typedef enum logic [2:0] {
    BK_IDLE     = 3'd0,
    BK_ACTIVE   = 3'd1,
    BK_READ     = 3'd2,
    BK_WRITE    = 3'd3,
    BK_READ_AP  = 3'd4,
    BK_WRITE_AP = 3'd5,
    BK_PRECH    = 3'd6
  } bank_st_e;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5,
    CMD_REF = 3'd6,
    CMD_LMR = 3'd7
  } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_BST;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_LMR;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_legality.sv
module sdram_cmd_legality
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  cmd_e                        cmd,
  input  logic [BA_W-1:0]             ba,
  input  logic                        a10,
  input  logic [NUM_BANKS*ST_W-1:0]   states,
  output logic                        legal
);

  bank_st_e st_a [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_unpack
    assign st_a[i] = bank_st_e'(states[i*ST_W +: ST_W]);
  end

  logic     all_idle;
  logic     any_ap;
  bank_st_e tgt;

  always_comb begin
    all_idle = 1'b1;
    any_ap   = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st_a[i] != BK_IDLE) all_idle = 1'b0;
      if (st_a[i] == BK_READ_AP || st_a[i] == BK_WRITE_AP) any_ap = 1'b1;
    end
  end

  assign tgt = st_a[ba];

  always_comb begin
    case (cmd)
      CMD_NOP: legal = 1'b1;
      CMD_ACT: legal = (tgt == BK_IDLE);
      CMD_RD,
      CMD_WR:  legal = (tgt == BK_ACTIVE) || (tgt == BK_READ) || (tgt == BK_WRITE);
      CMD_PRE: legal = a10 ? !any_ap
                           : !((tgt == BK_READ_AP) || (tgt == BK_WRITE_AP));
      CMD_BST: legal = (tgt == BK_READ) || (tgt == BK_WRITE);
      CMD_REF,
      CMD_LMR: legal = all_idle;
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BANK_IDX  = 0,
  parameter int BA_W      = 2,
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output bank_st_e        st
);

  localparam int MAX_T = (BURST_LEN > T_RP)
                         ? ((BURST_LEN > T_WR) ? BURST_LEN : T_WR)
                         : ((T_RP > T_WR) ? T_RP : T_WR);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] BL_M1 = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W-1:0] RP_M1 = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] WR_M1 = CNT_W'(T_WR - 1);

  logic [CNT_W-1:0] cnt;
  logic             rec;

  logic hit, is_burst, burst_hit, other_burst, pre_hit, bst_hit, act_hit;

  assign hit         = (ba == BA_W'(BANK_IDX));
  assign is_burst    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign burst_hit   = go && hit && is_burst;
  assign other_burst = go && !hit && is_burst;
  assign pre_hit     = go && (cmd == CMD_PRE) && (hit || a10);
  assign bst_hit     = go && hit && (cmd == CMD_BST);
  assign act_hit     = go && hit && (cmd == CMD_ACT);

  function automatic bank_st_e burst_state(input cmd_e c, input logic ap);
    if (c == CMD_RD) return ap ? BK_READ_AP : BK_READ;
    return ap ? BK_WRITE_AP : BK_WRITE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      cnt <= '0;
      rec <= 1'b0;
    end else begin
      case (st)
        BK_IDLE: begin
          if (act_hit) st <= BK_ACTIVE;
        end
        BK_ACTIVE: begin
          if (burst_hit) begin
            st  <= burst_state(cmd, a10);
            cnt <= BL_M1;
          end else if (pre_hit) begin
            st  <= BK_PRECH;
            cnt <= RP_M1;
          end
        end
        BK_READ, BK_WRITE: begin
          if (burst_hit) begin
            st  <= burst_state(cmd, a10);
            cnt <= BL_M1;
          end else if (bst_hit) begin
            st <= BK_ACTIVE;
          end else if (pre_hit) begin
            st  <= BK_PRECH;
            cnt <= RP_M1;
          end else if (other_burst || cnt == '0) begin
            st <= BK_ACTIVE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_READ_AP: begin
          if (other_burst || cnt == '0) begin
            st  <= BK_PRECH;
            cnt <= RP_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_WRITE_AP: begin
          if (!rec) begin
            if (other_burst || cnt == '0) begin
              rec <= 1'b1;
              cnt <= WR_M1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end else if (cnt == '0) begin
            st  <= BK_PRECH;
            rec <= 1'b0;
            cnt <= RP_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_PRECH: begin
          if (cnt == '0) st <= BK_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: begin
          st  <= BK_IDLE;
          cnt <= '0;
          rec <= 1'b0;
        end
      endcase
    end
  end

  // R2: an accepted ACTIVE opens the row on the next cycle
  a_r2_act_opens_row: assert property (@(posedge clk) disable iff (rst)
    act_hit |=> (st == BK_ACTIVE));

  // R8: read with auto precharge closes on the interrupting edge
  a_r8_rdap_cut_precharges: assert property (@(posedge clk) disable iff (rst)
    (other_burst && st == BK_READ_AP) |=> (st == BK_PRECH));

  // R9: a write with auto precharge still bursting waits for recovery
  a_r9_wrap_waits_recovery: assert property (@(posedge clk) disable iff (rst)
    (other_burst && st == BK_WRITE_AP && !rec) |=> (st == BK_WRITE_AP));

  // R4: precharging only ever leads to idle
  a_r4_prech_to_idle: assert property (@(posedge clk) disable iff (rst)
    (st == BK_PRECH) |=> (st == BK_PRECH || st == BK_IDLE));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  output logic [NUM_BANKS*ST_W-1:0] bank_state_o,
  output logic                      illegal_o
);

  cmd_e cmd;
  logic legal;
  logic cke_prev;
  logic cmd_ok;
  logic go;

  sdram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdram_cmd_legality #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_legal (
    .cmd    (cmd),
    .ba     (ba),
    .a10    (a10),
    .states (bank_state_o),
    .legal  (legal)
  );

  assign cmd_ok = cke && cke_prev;
  assign go     = cmd_ok && legal;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_st_e st_i;
    sdram_bank_fsm #(
      .BANK_IDX  (i),
      .BA_W      (BA_W),
      .BURST_LEN (BURST_LEN),
      .T_RP      (T_RP),
      .T_WR      (T_WR)
    ) u_fsm (
      .clk (clk),
      .rst (rst),
      .go  (go),
      .cmd (cmd),
      .ba  (ba),
      .a10 (a10),
      .st  (st_i)
    );
    assign bank_state_o[i*ST_W +: ST_W] = st_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev  <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      cke_prev  <= cke;
      illegal_o <= cmd_ok && !legal;
    end
  end

  logic banks_idle;
  always_comb begin
    banks_idle = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_state_o[i*ST_W +: ST_W] != BK_IDLE) banks_idle = 1'b0;
  end

  // R11: an ungated cycle never produces the flag
  a_r11_cke_gates_flag: assert property (@(posedge clk) disable iff (rst)
    !cmd_ok |=> !illegal_o);

  // R10: refresh or mode load with a busy bank is flagged
  a_r10_busy_refresh_flagged: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && (cmd == CMD_REF || cmd == CMD_LMR) && !banks_idle) |=> illegal_o);

endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb_top;

  localparam int CLK_P = 10;
  localparam int NB    = 4;
  localparam int BL    = 4;
  localparam int TRP   = 3;
  localparam int TWR   = 2;

  // bench command numbering
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3,
                 C_PRE = 4, C_BST = 5, C_REF = 6, C_LMR = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [NB*3-1:0] bank_state_o;
  logic illegal_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_bank_tracker #(
    .NUM_BANKS (NB),
    .BURST_LEN (BL),
    .T_RP      (TRP),
    .T_WR      (TWR)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .a10          (a10),
    .bank_state_o (bank_state_o),
    .illegal_o    (illegal_o)
  );

  // ---------------- bench model built from the requirements -------------
  int m_st  [NB];
  int m_cnt [NB];
  bit m_rec [NB];
  bit m_prev_cke;
  bit exp_ill;

  function automatic logic [3:0] enc(input int c);
    case (c)
      C_ACT:   return 4'b0011;
      C_RD:    return 4'b0101;
      C_WR:    return 4'b0100;
      C_PRE:   return 4'b0010;
      C_BST:   return 4'b0110;
      C_REF:   return 4'b0001;
      C_LMR:   return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic bit mdl_legal(input int c, input int b, input bit ap);
    bit idle_all = 1;
    bit ap_any = 0;
    for (int i = 0; i < NB; i++) begin
      if (m_st[i] != 0) idle_all = 0;
      if (m_st[i] == 4 || m_st[i] == 5) ap_any = 1;
    end
    case (c)
      C_ACT:        return m_st[b] == 0;
      C_RD, C_WR:   return m_st[b] >= 1 && m_st[b] <= 3;
      C_PRE:        return ap ? !ap_any : !(m_st[b] == 4 || m_st[b] == 5);
      C_BST:        return m_st[b] == 2 || m_st[b] == 3;
      C_REF, C_LMR: return idle_all;
      default:      return 1;
    endcase
  endfunction

  function automatic void mdl_step(input int c, input int b, input bit ap, input bit ck);
    bit valid = ck && m_prev_cke;
    bit lg = mdl_legal(c, b, ap);
    bit go = valid && lg;
    m_prev_cke = ck;
    exp_ill = valid && !lg;
    for (int i = 0; i < NB; i++) begin
      bit hit = (b == i);
      bit bh  = go && hit && (c == C_RD || c == C_WR);
      bit ob  = go && !hit && (c == C_RD || c == C_WR);
      bit ph  = go && c == C_PRE && (hit || ap);
      bit sh  = go && hit && c == C_BST;
      int bs  = (c == C_RD) ? (ap ? 4 : 2) : (ap ? 5 : 3);
      case (m_st[i])
        0: if (go && hit && c == C_ACT) m_st[i] = 1;
        1: if (bh) begin m_st[i] = bs; m_cnt[i] = BL - 1; end
           else if (ph) begin m_st[i] = 6; m_cnt[i] = TRP - 1; end
        2, 3: if (bh) begin m_st[i] = bs; m_cnt[i] = BL - 1; end
              else if (sh) m_st[i] = 1;
              else if (ph) begin m_st[i] = 6; m_cnt[i] = TRP - 1; end
              else if (ob || m_cnt[i] == 0) m_st[i] = 1;
              else m_cnt[i]--;
        4: if (ob || m_cnt[i] == 0) begin m_st[i] = 6; m_cnt[i] = TRP - 1; end
           else m_cnt[i]--;
        5: if (!m_rec[i]) begin
             if (ob || m_cnt[i] == 0) begin m_rec[i] = 1; m_cnt[i] = TWR - 1; end
             else m_cnt[i]--;
           end else if (m_cnt[i] == 0) begin
             m_st[i] = 6; m_rec[i] = 0; m_cnt[i] = TRP - 1;
           end else m_cnt[i]--;
        6: if (m_cnt[i] == 0) m_st[i] = 0; else m_cnt[i]--;
        default: m_st[i] = 0;
      endcase
    end
  endfunction

  function automatic logic [NB*3-1:0] mdl_vec();
    logic [NB*3-1:0] v;
    for (int i = 0; i < NB; i++) v[i*3 +: 3] = 3'(m_st[i]);
    return v;
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      C_ACT:        return "R2";
      C_RD, C_WR:   return "R3";
      C_PRE:        return "R5";
      C_BST:        return "R6";
      C_REF, C_LMR: return "R10";
      default:      return "R1";
    endcase
  endfunction

  // ---------------- checking helpers -------------------------------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_bank(input string tag, input int b, input int v);
    chk(tag, 32'(bank_state_o[b*3 +: 3]), 32'(v));
  endtask

  task automatic step(input int c, input int b, input bit ap, input bit ck, input bit desel);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = enc(c);
    if (desel) cs_n = 1'b1;
    ba = 2'(b); a10 = ap; cke = ck;
    @(posedge clk);
    mdl_step(desel ? C_NOP : c, b, ap, ck);
    #1;
    chk(tag_of(c), 32'(bank_state_o), 32'(mdl_vec()));
    chk("R12", 32'(illegal_o), 32'(exp_ill));
  endtask

  task automatic nop(input int n);
    for (int k = 0; k < n; k++) step(C_NOP, 0, 0, 1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_cnt[i] = 0; m_rec[i] = 0; end
    m_prev_cke = 0;
    chk("R13", 32'(bank_state_o), 32'd0);
    chk("R13", 32'(illegal_o), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    nop(1);
  endtask

  // ---------------- watchdog ---------------------------------------------
  initial begin
    #(CLK_P * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ---------------------------------------------
  initial begin
    void'($urandom(32'd4711));
    do_reset();

    // R2, R3, R12: open a row, reject a second ACTIVE, plain read returns to row open
    step(C_ACT, 0, 0, 1, 0); expect_bank("R2", 0, 1);
    step(C_ACT, 0, 0, 1, 0); chk("R12", 32'(illegal_o), 1); expect_bank("R12", 0, 1);
    step(C_RD, 0, 0, 1, 0);  expect_bank("R3", 0, 2);
    nop(3);                  expect_bank("R3", 0, 2);
    nop(1);                  expect_bank("R3", 0, 1);
    step(C_RD, 2, 0, 1, 0);  chk("R3", 32'(illegal_o), 1);

    // R1: deselect with ACTIVE strobes changes nothing
    step(C_ACT, 1, 0, 1, 1); expect_bank("R1", 1, 0); chk("R1", 32'(illegal_o), 0);

    // R4: natural ends of auto-precharge bursts and the precharge window
    do_reset();
    step(C_ACT, 0, 0, 1, 0);
    step(C_RD, 0, 1, 1, 0);  expect_bank("R4", 0, 4);
    nop(3);                  expect_bank("R4", 0, 4);
    nop(1);                  expect_bank("R4", 0, 6);
    nop(2);                  expect_bank("R4", 0, 6);
    nop(1);                  expect_bank("R4", 0, 0);
    step(C_ACT, 0, 0, 1, 0);
    step(C_WR, 0, 1, 1, 0);  expect_bank("R4", 0, 5);
    nop(5);                  expect_bank("R4", 0, 5);
    nop(1);                  expect_bank("R4", 0, 6);

    // R7, R8: cross-bank interruption
    do_reset();
    step(C_ACT, 0, 0, 1, 0); step(C_ACT, 1, 0, 1, 0); step(C_ACT, 2, 0, 1, 0);
    step(C_RD, 0, 1, 1, 0);  expect_bank("R8", 0, 4);
    step(C_RD, 1, 0, 1, 0);  expect_bank("R8", 0, 6); expect_bank("R7", 1, 2);
    step(C_WR, 2, 0, 1, 0);  expect_bank("R7", 1, 1); expect_bank("R7", 2, 3);

    // R9: interrupted write with auto precharge waits T_WR
    do_reset();
    step(C_ACT, 0, 0, 1, 0); step(C_ACT, 1, 0, 1, 0);
    step(C_WR, 0, 1, 1, 0);
    step(C_WR, 1, 0, 1, 0);  expect_bank("R9", 0, 5);
    nop(1);                  expect_bank("R9", 0, 5);
    nop(1);                  expect_bank("R9", 0, 6);

    // R5, R6: precharge and burst stop rules
    do_reset();
    step(C_ACT, 0, 0, 1, 0); step(C_ACT, 1, 0, 1, 0);
    step(C_RD, 0, 0, 1, 0);
    step(C_BST, 1, 0, 1, 0); chk("R6", 32'(illegal_o), 1); expect_bank("R6", 0, 2);
    step(C_BST, 0, 0, 1, 0); expect_bank("R6", 0, 1);
    step(C_RD, 0, 1, 1, 0);
    step(C_PRE, 0, 0, 1, 0); chk("R5", 32'(illegal_o), 1);
    step(C_PRE, 1, 1, 1, 0); chk("R5", 32'(illegal_o), 1); expect_bank("R5", 1, 1);
    do_reset();
    step(C_ACT, 0, 0, 1, 0); step(C_ACT, 3, 0, 1, 0);
    step(C_PRE, 1, 1, 1, 0); chk("R5", 32'(illegal_o), 0);
    expect_bank("R5", 0, 6); expect_bank("R5", 3, 6); expect_bank("R5", 1, 0);

    // R10: refresh and mode load need all banks idle
    do_reset();
    step(C_REF, 0, 0, 1, 0); chk("R10", 32'(illegal_o), 0);
    step(C_ACT, 2, 0, 1, 0);
    step(C_REF, 0, 0, 1, 0); chk("R10", 32'(illegal_o), 1);
    step(C_LMR, 0, 0, 1, 0); chk("R10", 32'(illegal_o), 1); expect_bank("R10", 2, 1);

    // R11: clock-enable gating
    do_reset();
    step(C_ACT, 0, 0, 0, 0); expect_bank("R11", 0, 0);
    step(C_ACT, 0, 0, 1, 0); expect_bank("R11", 0, 0);
    step(C_ACT, 0, 0, 1, 0); expect_bank("R11", 0, 1);
    step(C_LMR, 0, 0, 0, 0); chk("R11", 32'(illegal_o), 0);

    // random mix compared against the model every cycle
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 100);
      int c;
      if      (r < 25) c = C_ACT;
      else if (r < 45) c = C_RD;
      else if (r < 60) c = C_WR;
      else if (r < 70) c = C_PRE;
      else if (r < 78) c = C_BST;
      else if (r < 82) c = C_REF;
      else if (r < 84) c = C_LMR;
      else             c = C_NOP;
      step(c, int'($urandom % NB), bit'($urandom % 2), ($urandom % 20) != 0, ($urandom % 25) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule